// File: doc/BRIEF.md
# Bank-Bound Send Bus Arbiter

This block decides which module may drive each outbound send bus. There is one send bus for each external memory bank. A module is tied to one bank through a small binding table, which is written when the module is started. After that, the module may only ask for the bus of that bank. A free bus is granted to one of the modules asking for it. The module keeps the grant until it raises its release line. The return path for received data runs separately and does not pass through this block.

Every bus has its own round-robin pointer, so modules bound to the same bank take turns. A module that finds its bus taken simply keeps requesting, and the wait counts toward its latency. A release from a module that holds no bus is treated as a protocol slip: it changes nothing, and it sets an error flag that stays up until reset.

Top module: `sendbus_arb`

## Requirements
- R1: Reset has the following effects:
  - all grants are cleared and every bus is marked free;
  - every bus owner output reads 0 and the error flag reads 0;
  - every module is bound to bank 0.
- R2: A write on the binding port (`bind_we_i` high, module index `bind_mod_i`, bank `bind_bank_i`) takes effect at the next clock edge. After that, the module competes only for the bus whose index equals its bound bank.
- R3: A module is considered for a bus when its request is high and its bound bank is that bus. If the bus is free in that cycle, one candidate receives `gnt_o[m]` and `bus_busy_o[b]` is set, both visible right after the next clock edge.
- R4: A grant stays asserted while its owner keeps its release low, whether or not the request is still high.
- R5: A release from the owner frees the bus right after the next clock edge. A request that is high during the release cycle itself is not served in that cycle. The earliest new grant on that bus therefore follows a cycle later.
- R6: Each bus keeps a round-robin pointer that starts at module 0. The winner is the first candidate at or above the pointer, wrapping past the highest index. After module k wins, the pointer moves to k+1, wrapping to 0.
- R7: Buses are arbitrated independently, so different buses can be granted to different modules in the same cycle.
- R8: A release from a module that holds no bus changes no grant. It sets `rel_err_o` at the next edge, and the flag stays set until reset.
- R9: A binding write to a module that currently holds a grant is ignored, and its old bank stays in force.
- R10: `bus_owner_o` field b (bits b*MW to b*MW+MW-1, MW = clog2(N_MOD)) holds the index of the module holding bus b. It reads 0 while bus b is free.
- R11: A bus has at most one holder and a module holds at most one bus, so the number of grants always equals the number of busy buses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MOD | Send request, one bit per module |
| rel_i | input | N_MOD | Bus release, one bit per module |
| bind_we_i | input | 1 | Binding table write strobe |
| bind_mod_i | input | MW | Module index for the binding write |
| bind_bank_i | input | BW | Bank assigned by the binding write |
| gnt_o | output | N_MOD | Send grant, one bit per module |
| bus_busy_o | output | N_BUS | Bus held, one bit per bus |
| bus_owner_o | output | N_BUS*MW | Holder index per bus, packed |
| rel_err_o | output | 1 | Sticky flag for a release from a non-holder |

## Verification
The main stimulus is a burst where all six modules request at once across four banks. This shows that buses with one candidate and buses with two candidates are arbitrated in parallel.

Several patterns follow from there:
- A release followed by continued requests from both bank-0 modules separates a rotating pointer from a fixed priority.
- A request raised in the same cycle as a release separates a one-cycle handover from the two-cycle handover required.
- A rebinding attempt on a holder, followed by its release and re-request, shows whether the bank table was wrongly updated. The module is then granted either on its old bus or not at all.
- A release from an idle module, followed by quiet cycles, tells a sticky flag from a pulse.

// File: rtl/sba_pkg.sv
package sba_pkg;

  // Round-robin search: first set bit of cand at or above start, wrapping at n.
  // Returns n when no bit is set.
  function automatic int unsigned rr_pick(logic [31:0] cand, int unsigned start,
                                          int unsigned n);
    int unsigned res;
    res = n;
    for (int unsigned off = 0; off < 32; off++) begin
      int unsigned idx;
      idx = start + off;
      if (idx >= n) idx = idx - n;
      if (off < n && res == n && cand[idx]) res = idx;
    end
    return res;
  endfunction

  // Successor index with wrap at n.
  function automatic int unsigned wrap_inc(int unsigned i, int unsigned n);
    return (i + 1 >= n) ? 0 : i + 1;
  endfunction

endpackage

// File: rtl/sba_bind_table.sv
module sba_bind_table #(
  parameter int N_MOD = 6,
  parameter int N_BUS = 4,
  localparam int MW = $clog2(N_MOD),
  localparam int BW = $clog2(N_BUS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [MW-1:0]       mod,
  input  logic [BW-1:0]       bank,
  input  logic [N_MOD-1:0]    held,
  output logic [N_MOD*BW-1:0] bank_of
);

  logic [BW-1:0] tbl [N_MOD];
  logic          wr_ok;

  // R9: holders keep their binding; out-of-range indices are dropped
  assign wr_ok = we && (int'(mod) < N_MOD) && !held[mod];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < N_MOD; m++) tbl[m] <= '0;
    end else if (wr_ok) begin
      tbl[mod] <= bank;
    end
  end

  for (genvar m = 0; m < N_MOD; m++) begin : g_out
    assign bank_of[m*BW +: BW] = tbl[m];
  end

endmodule

// File: rtl/sba_bus_slot.sv
module sba_bus_slot #(
  parameter int N_MOD = 6,
  localparam int MW = $clog2(N_MOD)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_MOD-1:0] cand,
  input  logic [N_MOD-1:0] rel,
  output logic             busy,
  output logic [MW-1:0]    owner,
  output logic             fire_grant,
  output logic             fire_free
);
  import sba_pkg::*;

  logic [MW-1:0] ptr;
  int unsigned   pick;
  logic [MW-1:0] pick_idx;

  assign pick     = rr_pick(32'(cand), int'(ptr), N_MOD);
  assign pick_idx = MW'(pick);

  // R5: only the holder's release frees the bus
  assign fire_free  = busy && rel[owner];
  // R3: a free bus with any candidate is granted
  assign fire_grant = !busy && (pick < N_MOD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      owner <= '0;
      ptr   <= '0;
    end else if (fire_free) begin
      busy  <= 1'b0;
      owner <= '0;
    end else if (fire_grant) begin
      busy  <= 1'b1;
      owner <= pick_idx;
      ptr   <= MW'(wrap_inc(pick, N_MOD));  // R6
    end
  end

endmodule

// File: rtl/sendbus_arb.sv
module sendbus_arb #(
  parameter int N_MOD = 6,
  parameter int N_BUS = 4,
  localparam int MW = $clog2(N_MOD),
  localparam int BW = $clog2(N_BUS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [N_MOD-1:0]    req_i,
  input  logic [N_MOD-1:0]    rel_i,
  input  logic                bind_we_i,
  input  logic [MW-1:0]       bind_mod_i,
  input  logic [BW-1:0]       bind_bank_i,
  output logic [N_MOD-1:0]    gnt_o,
  output logic [N_BUS-1:0]    bus_busy_o,
  output logic [N_BUS*MW-1:0] bus_owner_o,
  output logic                rel_err_o
);

  logic [N_MOD*BW-1:0] bank_of;
  logic [N_MOD-1:0]    cand     [N_BUS];
  logic [N_BUS-1:0]    ev_grant;
  logic [N_BUS-1:0]    ev_free;
  logic [MW-1:0]       own      [N_BUS];
  logic                bad_rel;
  logic                err_q;

  sba_bind_table #(.N_MOD(N_MOD), .N_BUS(N_BUS)) u_tbl (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (bind_we_i),
    .mod     (bind_mod_i),
    .bank    (bind_bank_i),
    .held    (gnt_o),
    .bank_of (bank_of)
  );

  for (genvar b = 0; b < N_BUS; b++) begin : g_bus
    // R2: only modules bound to this bank compete here
    always_comb begin
      for (int m = 0; m < N_MOD; m++)
        cand[b][m] = req_i[m] && !gnt_o[m] && (int'(bank_of[m*BW +: BW]) == b);
    end

    sba_bus_slot #(.N_MOD(N_MOD)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .cand       (cand[b]),
      .rel        (rel_i),
      .busy       (bus_busy_o[b]),
      .owner      (own[b]),
      .fire_grant (ev_grant[b]),
      .fire_free  (ev_free[b])
    );

    assign bus_owner_o[b*MW +: MW] = own[b];  // R10
  end

  always_comb begin
    gnt_o = '0;
    for (int b = 0; b < N_BUS; b++)
      if (bus_busy_o[b]) gnt_o[own[b]] = 1'b1;
  end

  // R8: release from a module that holds nothing
  assign bad_rel = |(rel_i & ~gnt_o);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (bad_rel) err_q <= 1'b1;
  end

  assign rel_err_o = err_q;

endmodule

// File: rtl/sba_chk.sv
module sba_chk #(
  parameter int N_MOD = 6,
  parameter int N_BUS = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_MOD-1:0] req_i,
  input logic [N_MOD-1:0] rel_i,
  input logic [N_MOD-1:0] gnt_o,
  input logic [N_BUS-1:0] bus_busy_o,
  input logic             rel_err_o,
  input logic             bad_rel
);

  // R3
  grant_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((gnt_o & ~$past(gnt_o)) & ~$past(req_i)) == '0);

  // R4
  grant_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(gnt_o) & ~$past(rel_i)) & ~gnt_o) == '0);

  // R5
  release_frees_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(gnt_o) & $past(rel_i)) & gnt_o) == '0);

  // R8
  bad_release_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad_rel |=> rel_err_o);

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err_o |=> rel_err_o);

  // R11
  one_holder_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(gnt_o) == $countones(bus_busy_o));

endmodule

bind sendbus_arb sba_chk #(.N_MOD(N_MOD), .N_BUS(N_BUS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_i      (req_i),
  .rel_i      (rel_i),
  .gnt_o      (gnt_o),
  .bus_busy_o (bus_busy_o),
  .rel_err_o  (rel_err_o),
  .bad_rel    (bad_rel)
);

// File: tb/test_sendbus_arb.sv
module test_sendbus_arb;
  localparam int N_MOD = 6;
  localparam int N_BUS = 4;
  localparam int MW = 3;
  localparam int BW = 2;
  localparam int NV = 20;

  typedef struct packed {
    logic [3:0] tag;
    logic       we;
    logic [2:0] wm;
    logic [1:0] wb;
    logic [5:0] req;
    logic [5:0] rel;
    logic [5:0] gnt;
    logic [3:0] busy;
    logic       err;
    logic [2:0] own0;
  } vec_t;

  localparam vec_t TBL [NV] = '{
    '{4'd2,  1'b1, 3'd1, 2'd1, 6'b000000, 6'b000000, 6'b000000, 4'b0000, 1'b0, 3'd0}, // R2
    '{4'd2,  1'b1, 3'd2, 2'd1, 6'b000000, 6'b000000, 6'b000000, 4'b0000, 1'b0, 3'd0}, // R2
    '{4'd2,  1'b1, 3'd3, 2'd2, 6'b000000, 6'b000000, 6'b000000, 4'b0000, 1'b0, 3'd0}, // R2
    '{4'd2,  1'b1, 3'd4, 2'd3, 6'b000000, 6'b000000, 6'b000000, 4'b0000, 1'b0, 3'd0}, // R2
    '{4'd7,  1'b0, 3'd0, 2'd0, 6'b111111, 6'b000000, 6'b011011, 4'b1111, 1'b0, 3'd0}, // R7
    '{4'd4,  1'b0, 3'd0, 2'd0, 6'b111111, 6'b000000, 6'b011011, 4'b1111, 1'b0, 3'd0}, // R4
    '{4'd5,  1'b0, 3'd0, 2'd0, 6'b111111, 6'b000001, 6'b011010, 4'b1110, 1'b0, 3'd0}, // R5
    '{4'd6,  1'b0, 3'd0, 2'd0, 6'b111111, 6'b000000, 6'b111010, 4'b1111, 1'b0, 3'd5}, // R6
    '{4'd5,  1'b0, 3'd0, 2'd0, 6'b011101, 6'b100010, 6'b011000, 4'b1100, 1'b0, 3'd0}, // R5
    '{4'd3,  1'b0, 3'd0, 2'd0, 6'b011101, 6'b000000, 6'b011101, 4'b1111, 1'b0, 3'd0}, // R3
    '{4'd8,  1'b0, 3'd0, 2'd0, 6'b011101, 6'b000010, 6'b011101, 4'b1111, 1'b1, 3'd0}, // R8
    '{4'd8,  1'b0, 3'd0, 2'd0, 6'b000000, 6'b000000, 6'b011101, 4'b1111, 1'b1, 3'd0}, // R8 R4
    '{4'd9,  1'b1, 3'd2, 2'd0, 6'b000000, 6'b000000, 6'b011101, 4'b1111, 1'b1, 3'd0}, // R9
    '{4'd5,  1'b0, 3'd0, 2'd0, 6'b000000, 6'b000100, 6'b011001, 4'b1101, 1'b1, 3'd0}, // R5
    '{4'd9,  1'b0, 3'd0, 2'd0, 6'b000100, 6'b000000, 6'b011101, 4'b1111, 1'b1, 3'd0}, // R9
    '{4'd5,  1'b0, 3'd0, 2'd0, 6'b000100, 6'b000100, 6'b011001, 4'b1101, 1'b1, 3'd0}, // R5
    '{4'd3,  1'b0, 3'd0, 2'd0, 6'b000100, 6'b000000, 6'b011101, 4'b1111, 1'b1, 3'd0}, // R3
    '{4'd5,  1'b0, 3'd0, 2'd0, 6'b000000, 6'b011101, 6'b000000, 4'b0000, 1'b1, 3'd0}, // R5
    '{4'd2,  1'b1, 3'd2, 2'd0, 6'b000000, 6'b000000, 6'b000000, 4'b0000, 1'b1, 3'd0}, // R2
    '{4'd6,  1'b0, 3'd0, 2'd0, 6'b100101, 6'b000000, 6'b000100, 4'b0001, 1'b1, 3'd2}  // R6 R10
  };

  logic                clk = 1'b0;
  logic                rst_n = 1'b0;
  logic [N_MOD-1:0]    req = '0;
  logic [N_MOD-1:0]    rel = '0;
  logic                bwe = 1'b0;
  logic [MW-1:0]       bmod = '0;
  logic [BW-1:0]       bbank = '0;
  logic [N_MOD-1:0]    gnt;
  logic [N_BUS-1:0]    busy;
  logic [N_BUS*MW-1:0] owner;
  logic                err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sendbus_arb #(.N_MOD(N_MOD), .N_BUS(N_BUS)) i_sendbus_arb (
    .clk(clk), .rst_n(rst_n), .req_i(req), .rel_i(rel),
    .bind_we_i(bwe), .bind_mod_i(bmod), .bind_bank_i(bbank),
    .gnt_o(gnt), .bus_busy_o(busy), .bus_owner_o(owner), .rel_err_o(err)
  );

  task automatic chk(input string r, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", r, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: state during and right after reset
    chk("R1", "gnt", int'(gnt), 0);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "owner", int'(owner), 0);
    chk("R1", "err", int'(err), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = $sformatf("R%0d", TBL[i].tag);
      bwe = TBL[i].we; bmod = TBL[i].wm; bbank = TBL[i].wb;
      req = TBL[i].req; rel = TBL[i].rel;
      @(negedge clk);
      chk(tg, $sformatf("row %0d gnt", i), int'(gnt), int'(TBL[i].gnt));
      chk(tg, $sformatf("row %0d busy", i), int'(busy), int'(TBL[i].busy));
      chk(tg, $sformatf("row %0d err", i), int'(err), int'(TBL[i].err));
      chk("R10", $sformatf("row %0d owner0", i), int'(owner[MW-1:0]), int'(TBL[i].own0));
      chk("R11", $sformatf("row %0d count", i), $countones(gnt), $countones(busy));
    end

    bwe = 1'b0; req = '0; rel = '0;
    // R10: other owner fields after the table
    chk("R10", "owner bus2", int'(owner[2*MW +: MW]), 0);
    // R1: reset mid-run clears grants, flag and bindings
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "gnt after reset", int'(gnt), 0);
    chk("R1", "err after reset", int'(err), 0);
    rst_n = 1'b1;
    // R1 R2: module 1 is back on bank 0 after reset
    req = 6'b000010;
    @(negedge clk);
    chk("R1", "rebound gnt", int'(gnt), 6'b000010);
    chk("R10", "owner bus0", int'(owner[MW-1:0]), 1);
    chk("R2", "busy after reset bind", int'(busy), 4'b0001);
    req = '0;
    @(negedge clk);
    finish_run();
  end

endmodule